// File: doc/BRIEF.md
# Dual Tone Programmable Generator

This block produces two square-wave tones, a high-group tone and a low-group tone, for signalling paths that need paired tones. Both run from a single reference clock enable (nominally 1.2 MHz, one pulse per reference period). Each tone has an 8-bit divisor code. The high tone's period is the code times 6 enable ticks. The low tone's period is the code times 14 enable ticks. Three code values have special meanings: 2 silences a tone, and 0 or 1 select the longest periods.

Writing the low-tone code arms a timed burst. This is 115200 ticks by default, which is 96 ms at 1.2 MHz. When the burst expires, each tone finishes at its next high-to-low transition and then rests low. A continuous-mode input keeps the tones running with no timeout. A code written while a tone runs takes effect at the tone's next half-period boundary, so the waveform changes frequency without a phase jump. The analog summing and filtering that follow are outside this block.

Top module: `dual_tone_gen`

## Requirements
- R1: With high code D (3..255), tone_hi is a square wave with each half period lasting 3*D ticks of `tick`. It changes only on a clock edge where `tick` is 1.
- R2: With low code D (3..255), tone_lo is a square wave with each half period lasting 7*D ticks.
- R3: A `lo_wr` strobe arms a burst of BURST_TICKS ticks during which both non-silent tones run. A further `lo_wr` during a burst restarts the full count.
- R4: After the burst expires (with cont_mode low), each tone stops at its next high-to-low transition and stays low. `active` therefore falls no later than one period of the slower tone after the burst ends.
- R5: Code 2 silences a tone, which then stays low while the other tone runs. If code 2 is written while the tone runs, the tone stops at its next high-to-low transition.
- R6: Code 0 or 1 gives the high tone a divisor of 257 (half period 771 ticks) and the low tone a divisor of 256 (half period 1792 ticks).
- R7: While cont_mode is 1, non-silent tones run with no timeout. When cont_mode drops after the burst has expired, the tones stop as in R4.
- R8: A code written while a tone runs leaves the half period in progress unchanged. The new length applies from the following half period.
- R9: After reset, both codes hold 2 (silent) and tone_hi, tone_lo and active are 0. Whenever active is 0, both tones are 0. A tone starts high on the first tick at which it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference enable, one pulse per reference period |
| hi_wr | input | 1 | Write strobe for the high-tone code |
| lo_wr | input | 1 | Write strobe for the low-tone code; arms the burst |
| wr_code | input | 8 | Divisor code written by either strobe |
| cont_mode | input | 1 | 1 = run without timeout |
| tone_hi | output | 1 | High-group square wave |
| tone_lo | output | 1 | Low-group square wave |
| active | output | 1 | 1 while either tone is running |

## Verification
A wrong divisor or a wrong prescaler count shows up as a mistimed transition on a tone output within one half period. The bench measures the tick spacing between successive edges directly. A reload applied at the wrong moment stretches or shortens the half period in which it was written, so the bench measures that half period and the one after it. A burst timer or stop condition with the wrong state leaves `active` high too long, or lets it drop while a tone is still high. Both show within one tone period after the burst boundary.

// File: rtl/tone_pkg.sv
package tone_pkg;
   typedef enum logic {CH_IDLE = 1'b0, CH_RUN = 1'b1} ch_state_t;
   localparam int DEF_CODE_W = 8;
   localparam int DEF_SILENT = 2;
endpackage

// File: rtl/tone_chan.sv
module tone_chan
   import tone_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int PRE         = 6,
   parameter int ZERO_MAP    = 257,
   parameter int SILENT_CODE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic              ld,
   input  logic [CODE_W-1:0] ld_code,
   output logic              wave,
   output logic              busy
);
   localparam int HALF_PRE = PRE / 2;
   localparam int PRE_W    = (HALF_PRE > 1) ? $clog2(HALF_PRE) : 1;
   localparam int MAX_DIV  = (ZERO_MAP > (2**CODE_W) - 1) ? ZERO_MAP : (2**CODE_W) - 1;
   localparam int DIV_W    = $clog2(MAX_DIV + 1);
   localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(HALF_PRE - 1);
   localparam logic [CODE_W-1:0] SIL      = CODE_W'(SILENT_CODE);

   generate
      if (PRE < 2 || (PRE % 2) != 0) begin : g_bad_pre
         $error("tone_chan: PRE must be even and at least 2");
      end
      if (ZERO_MAP < 3) begin : g_bad_map
         $error("tone_chan: ZERO_MAP must be at least 3");
      end
   endgenerate

   function automatic logic [DIV_W-1:0] eff_div(input logic [CODE_W-1:0] c);
      if (c <= CODE_W'(1)) return DIV_W'(ZERO_MAP);
      else                 return DIV_W'(c);
   endfunction

   ch_state_t         state_q;
   logic [CODE_W-1:0] code_q;
   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  div_cnt;
   logic [PRE_W-1:0]  pre_cnt;
   logic              wave_q;

   logic silent, stop_req, step, term;
   always_comb begin
      silent   = (code_q == SIL);
      stop_req = !run || silent;
      step     = tick && (pre_cnt == PRE_LAST);
      term     = step && (div_cnt == div_q - DIV_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_IDLE;
         code_q  <= SIL;
         div_q   <= DIV_W'(ZERO_MAP);
         div_cnt <= '0;
         pre_cnt <= '0;
         wave_q  <= 1'b0;
      end else begin
         if (ld) code_q <= ld_code;
         case (state_q)
            CH_IDLE: begin
               if (tick && run && !silent) begin
                  state_q <= CH_RUN;
                  wave_q  <= 1'b1;
                  pre_cnt <= '0;
                  div_cnt <= '0;
                  div_q   <= eff_div(code_q);
               end
            end
            default: begin
               if (tick) begin
                  pre_cnt <= (pre_cnt == PRE_LAST) ? '0 : pre_cnt + PRE_W'(1);
                  if (term) begin
                     div_cnt <= '0;
                     if (wave_q && stop_req) begin
                        wave_q  <= 1'b0;
                        state_q <= CH_IDLE;
                     end else begin
                        wave_q <= !wave_q;
                        if (!silent) div_q <= eff_div(code_q);
                     end
                  end else if (step) begin
                     div_cnt <= div_cnt + DIV_W'(1);
                  end
               end
            end
         endcase
      end
   end

   assign wave = wave_q;
   assign busy = (state_q == CH_RUN);
endmodule

// File: rtl/burst_ctl.sv
module burst_ctl #(
   parameter int BURST_TICKS = 115200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic cont,
   output logic run,
   output logic burst_on
);
   localparam int TW = $clog2(BURST_TICKS + 1);
   localparam logic [TW-1:0] LOAD = TW'(BURST_TICKS);

   generate
      if (BURST_TICKS < 1) begin : g_bad_burst
         $error("burst_ctl: BURST_TICKS must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cnt_q;
   logic          on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         on_q  <= 1'b0;
      end else if (restart) begin
         cnt_q <= LOAD;
         on_q  <= 1'b1;
      end else if (tick && on_q) begin
         cnt_q <= cnt_q - TW'(1);
         if (cnt_q == TW'(1)) on_q <= 1'b0;
      end
   end

   assign run      = on_q || cont;
   assign burst_on = on_q;
endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen #(
   parameter int CODE_W      = 8,
   parameter int HI_PRE      = 6,
   parameter int LO_PRE      = 14,
   parameter int HI_ZERO_MAP = 257,
   parameter int LO_ZERO_MAP = 256,
   parameter int SILENT_CODE = 2,
   parameter int BURST_TICKS = 115200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              cont_mode,
   output logic              tone_hi,
   output logic              tone_lo,
   output logic              active
);
   localparam int N_CH = 2;

   generate
      if (CODE_W < 2) begin : g_bad_code
         $error("dual_tone_gen: CODE_W must be at least 2");
      end
   endgenerate

   logic            run_req;
   logic            burst_on;
   logic [N_CH-1:0] chan_wave;
   logic [N_CH-1:0] chan_busy;
   logic [N_CH-1:0] chan_ld;

   assign chan_ld = {lo_wr, hi_wr};

   burst_ctl #(.BURST_TICKS(BURST_TICKS)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .restart  (lo_wr),
      .cont     (cont_mode),
      .run      (run_req),
      .burst_on (burst_on)
   );

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      localparam int P = (g == 0) ? HI_PRE : LO_PRE;
      localparam int Z = (g == 0) ? HI_ZERO_MAP : LO_ZERO_MAP;
      tone_chan #(
         .CODE_W(CODE_W), .PRE(P), .ZERO_MAP(Z), .SILENT_CODE(SILENT_CODE)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .run     (run_req),
         .ld      (chan_ld[g]),
         .ld_code (wr_code),
         .wave    (chan_wave[g]),
         .busy    (chan_busy[g])
      );
   end

   assign tone_hi = chan_wave[0];
   assign tone_lo = chan_wave[1];
   assign active  = |chan_busy;
endmodule

// File: rtl/dual_tone_gen_chk.sv
module dual_tone_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic lo_wr,
   input logic tone_hi,
   input logic tone_lo,
   input logic active,
   input logic burst_on,
   input logic busy_hi
);
   assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!tone_hi && !tone_lo));

   assert_move_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(tone_hi) && $stable(tone_lo)));

   assert_burst_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr |=> burst_on);

   assert_stop_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_hi) |-> $fell(tone_hi));
endmodule

bind dual_tone_gen dual_tone_gen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .lo_wr    (lo_wr),
   .tone_hi  (tone_hi),
   .tone_lo  (tone_lo),
   .active   (active),
   .burst_on (burst_on),
   .busy_hi  (chan_busy[0])
);

// File: tb/sim_dual_tone_gen.sv
`timescale 1ns/1ps
module sim_dual_tone_gen;
   localparam int BT = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       hi_wr = 1'b0;
   logic       lo_wr = 1'b0;
   logic [7:0] wr_code = 8'd0;
   logic       cont_mode = 1'b0;
   logic       tone_hi, tone_lo, active;

   int n_chk = 0;
   int n_bad = 0;
   int tick_count = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dual_tone_gen #(.BURST_TICKS(BT)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hi_wr(hi_wr), .lo_wr(lo_wr),
      .wr_code(wr_code), .cont_mode(cont_mode),
      .tone_hi(tone_hi), .tone_lo(tone_lo), .active(active)
   );

   always @(posedge clk) if (tick) tick_count <= tick_count + 1;

   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         tick = (ph == 2);
         ph = (ph + 1) % 3;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic sel_tone(input bit lo);
      return lo ? tone_lo : tone_hi;
   endfunction

   task automatic wait_ticks(input int n);
      int s = tick_count;
      while (tick_count < s + n) @(negedge clk);
   endtask

   task automatic wait_edge(input bit lo, input bit rising);
      logic prev = sel_tone(lo);
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (rising ? (!prev && sel_tone(lo)) : (prev && !sel_tone(lo))) return;
         prev = sel_tone(lo);
      end
   endtask

   task automatic measure_half(input bit lo, input bit high_half, output int h);
      int t0;
      wait_edge(lo, high_half);
      t0 = tick_count;
      wait_edge(lo, !high_half);
      h = tick_count - t0;
   endtask

   task automatic wr(input bit lo, input logic [7:0] code);
      @(negedge clk);
      wr_code = code;
      if (lo) lo_wr = 1'b1; else hi_wr = 1'b1;
      @(negedge clk);
      lo_wr = 1'b0;
      hi_wr = 1'b0;
   endtask

   task automatic cleanup();
      cont_mode = 1'b0;
      wr(1'b0, 8'd2);
      wr(1'b1, 8'd2);
      for (int i = 0; i < 30000 && active; i++) @(negedge clk);
      wait_ticks(5);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(tone_hi == 0 && tone_lo == 0, "R9", "tones after reset", {tone_hi, tone_lo}, 0);
      check(active == 0, "R9", "active after reset", active, 0);
      cont_mode = 1'b1;
      wait_ticks(50);
      check(active == 0, "R9", "reset codes are silent", active, 0);
      cont_mode = 1'b0;
   endtask

   task automatic t_high_period();
      int h;
      cont_mode = 1'b1;
      wr(1'b0, 8'd5);
      measure_half(1'b0, 1'b1, h);
      check(h == 15, "R1", "high tone high half", h, 15);
      measure_half(1'b0, 1'b0, h);
      check(h == 15, "R1", "high tone low half", h, 15);
      check(tone_lo == 0, "R5", "silent low tone", tone_lo, 0);
      cleanup();
   endtask

   task automatic t_low_period();
      int h;
      cont_mode = 1'b1;
      wr(1'b1, 8'd4);
      measure_half(1'b1, 1'b1, h);
      check(h == 28, "R2", "low tone high half", h, 28);
      measure_half(1'b1, 1'b0, h);
      check(h == 28, "R2", "low tone low half", h, 28);
      cleanup();
   endtask

   task automatic t_zero_map();
      int h;
      cont_mode = 1'b1;
      wr(1'b0, 8'd0);
      wr(1'b1, 8'd1);
      measure_half(1'b0, 1'b1, h);
      check(h == 771, "R6", "high code 0 half period", h, 771);
      measure_half(1'b1, 1'b1, h);
      check(h == 1792, "R6", "low code 1 half period", h, 1792);
      cleanup();
   endtask

   task automatic t_reload();
      int t0, h;
      cont_mode = 1'b1;
      wr(1'b0, 8'd5);
      wait_edge(1'b0, 1'b1);
      t0 = tick_count;
      wait_ticks(5);
      wr(1'b0, 8'd10);
      wait_edge(1'b0, 1'b0);
      h = tick_count - t0;
      check(h == 15, "R8", "half in progress keeps old length", h, 15);
      t0 = tick_count;
      wait_edge(1'b0, 1'b1);
      h = tick_count - t0;
      check(h == 30, "R8", "next half uses new code", h, 30);
      cleanup();
   endtask

   task automatic t_burst();
      int t0, dur;
      cont_mode = 1'b0;
      wr(1'b0, 8'd5);
      wr(1'b1, 8'd3);
      t0 = tick_count;
      wait_ticks(100);
      check(active == 1, "R3", "active during burst", active, 1);
      for (int i = 0; i < 5000 && active; i++) @(negedge clk);
      dur = tick_count - t0;
      check(dur >= BT && dur <= BT + 45, "R4", "burst on-time ticks", dur, BT);
      check(tone_hi == 0 && tone_lo == 0, "R4", "tones low after burst", {tone_hi, tone_lo}, 0);
      cleanup();
   endtask

   task automatic t_restart();
      int t0, dur;
      cont_mode = 1'b0;
      wr(1'b1, 8'd3);
      wait_ticks(150);
      wr(1'b1, 8'd3);
      t0 = tick_count;
      wait_ticks(120);
      check(active == 1, "R3", "rewrite restarts burst", active, 1);
      for (int i = 0; i < 5000 && active; i++) @(negedge clk);
      dur = tick_count - t0;
      check(dur >= BT && dur <= BT + 45, "R3", "restarted burst length", dur, BT);
      cleanup();
   endtask

   task automatic t_cont();
      int h;
      cont_mode = 1'b1;
      wr(1'b1, 8'd3);
      wait_ticks(3 * BT + 100);
      check(active == 1, "R7", "continuous runs past burst", active, 1);
      measure_half(1'b1, 1'b1, h);
      check(h == 21, "R7", "continuous low tone half", h, 21);
      cont_mode = 1'b0;
      wait_ticks(50);
      check(active == 0, "R7", "stops after cont drop", active, 0);
      cleanup();
   endtask

   task automatic t_silence_mid();
      int highs = 0;
      int lo_edges = 0;
      logic plo;
      cont_mode = 1'b1;
      wr(1'b0, 8'd5);
      wr(1'b1, 8'd3);
      wait_edge(1'b0, 1'b1);
      wr(1'b0, 8'd2);
      wait_edge(1'b0, 1'b0);
      plo = tone_lo;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (tone_hi) highs++;
         if (tone_lo != plo) lo_edges++;
         plo = tone_lo;
      end
      check(highs == 0, "R5", "silenced high tone stays low", highs, 0);
      check(lo_edges > 0, "R5", "low tone keeps running", lo_edges, 1);
      check(active == 1, "R5", "active with one tone", active, 1);
      cleanup();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_high_period();
      t_low_period();
      t_zero_map();
      t_reload();
      t_burst();
      t_restart();
      t_cont();
      t_silence_mid();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog: actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule